// File: doc/BRIEF.md
# Handset Power-Up and Reset Sequencer

This block decides when the handset baseband is allowed to power on, and it keeps the microcontroller in reset until the supplies and the clock are ready. A power-on request can come from the power key (active low) or from the charger-detect input (active high). Either request passes through a two-flop synchroniser and a four-sample debounce. A valid request raises the regulator-and-MCU enable. A fixed settling interval follows. The sequencer then waits for the active-low PLL-ready input before it releases the active-low MCU reset.

Once the phone is running, the key and the charger cannot switch it off. The phone stops only when the active-low low-battery input is asserted. That input drops both outputs from any state and holds them low until it is released. A new power-on request is then needed. A built-in watchdog has to be serviced by a one-cycle kick strobe. If the watchdog expires, the MCU reset is pulled low for a fixed hold time while the enable stays high. The sequencer then goes back to waiting for the PLL.

Top module: `pwr_seq_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `reg_en` is 0 and `mcu_rst_n` is 0.
- R2: A power-key press (`pwr_key_n` = 0) held for at least 6 clock cycles raises `reg_en` within 20 cycles. A press of 2 cycles or fewer is filtered out and leaves `reg_en` at 0.
- R3: `chg_det` = 1, held for at least 6 cycles, starts power-up in the same way as the key.
- R4: After `reg_en` rises, `mcu_rst_n` stays 0 for at least ENABLE_CYCLES cycles. It stays 0 for as long as `pll_ready_n` is 1, and it goes to 1 within 6 cycles after `pll_ready_n` goes to 0 once that interval is over.
- R5: While running, changes on `pwr_key_n` and `chg_det` have no effect on `reg_en` or `mcu_rst_n`.
- R6: `lowbatt_n` = 0 brings `reg_en` and `mcu_rst_n` to 0 within 4 cycles from any state, including during power-up. After `lowbatt_n` returns to 1, both stay 0 until a new power-on request arrives.
- R7: If no kick arrives for WDOG_LOAD cycles while running, `mcu_rst_n` goes to 0 for between HOLD_CYCLES and HOLD_CYCLES+2 cycles with `reg_en` held at 1. It then returns to 1 if the PLL is ready.
- R8: A one-cycle `wdog_kick` pulse reloads the watchdog. A phone kicked more often than every WDOG_LOAD cycles keeps `mcu_rst_n` at 1.
- R9: `mcu_rst_n` is never 1 while `reg_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_key_n | input | 1 | Power key, low when pressed; power-on request only |
| chg_det | input | 1 | Charger present, high; power-on request only |
| lowbatt_n | input | 1 | Low-battery reset, low when active; asynchronous to clk |
| pll_ready_n | input | 1 | PLL-on delay, low when the clock is ready |
| wdog_kick | input | 1 | One-cycle watchdog service strobe, synchronous |
| reg_en | output | 1 | Enable for the receive regulator and the MCU |
| mcu_rst_n | output | 1 | Active-low MCU reset |

## Verification
The bench sends key pulses shorter than the debounce window. A design with a weak filter would power up on these glitches. It presses the key and toggles the charger while the phone runs, which exposes a design that lets these inputs turn the phone off. It asserts low battery during the settling interval, to catch a design that only looks at that input in the running state. It also holds the PLL not ready, to catch a design that releases reset on a timer alone. The length of the watchdog reset pulse is measured, and `reg_en` is checked throughout the pulse. A design that drops the enable on expiry, or that mis-sizes the hold time, fails these checks.

// File: rtl/pwr_seq_pkg.sv
// Shared types for the power-up sequencer.
// Assumes: one clock domain; all consumers import this package.
package pwr_seq_pkg;

    // Sequencer states; the enable is high in every state except OFF and FAULT.
    typedef enum logic [2:0] {
        PS_OFF       = 3'd0,
        PS_ENABLING  = 3'd1,
        PS_WAIT_PLL  = 3'd2,
        PS_RUN       = 3'd3,
        PS_WDOG_HOLD = 3'd4,
        PS_FAULT     = 3'd5
    } pwr_state_e;

endpackage

// File: rtl/pwr_seq_sync.sv
// Two-flop synchroniser for a bundle of independent level inputs.
// Assumes: each bit is a slow level; bits are not related to one another.
// The reset value is 0, so every input must already be polarity-adjusted
// such that 0 means "inactive".
module pwr_seq_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Purpose: two register stages that absorb metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_in;
            sync_q <= meta_q;
        end
    end

    assign d_out = sync_q;

endmodule

// File: rtl/pwr_seq_debounce.sv
// N-sample debounce. The output changes only after SAMPLES consecutive
// identical samples; otherwise it keeps its last value.
// Assumes: the input is already synchronised to clk.
module pwr_seq_debounce #(
    parameter int SAMPLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);

    logic [SAMPLES-1:0] hist_q;
    logic               out_q;

    // Purpose: shift in the newest sample and update the filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            out_q  <= 1'b0;
        end else begin
            hist_q <= {hist_q[SAMPLES-2:0], d_in};
            if (&hist_q)
                out_q <= 1'b1;
            else if (~|hist_q)
                out_q <= 1'b0;
        end
    end

    assign d_out = out_q;

endmodule

// File: rtl/pwr_seq_wdog.sv
// Watchdog down-counter. It is held at the reload value outside the run
// state and reloaded by a kick. It signals expiry when it reaches zero
// in the run state without a kick in that same cycle.
// Assumes: the kick is a synchronous one-cycle strobe; LOAD >= 2.
module pwr_seq_wdog #(
    parameter int WIDTH = 16,
    parameter int LOAD  = 65535
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic expire
);

    localparam logic [WIDTH-1:0] LOAD_V = WIDTH'(LOAD);

    logic [WIDTH-1:0] cnt_q;

    // Purpose: reload on kick or when idle, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= LOAD_V;
        else if (!run || kick)
            cnt_q <= LOAD_V;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = run && !kick && (cnt_q == '0);

endmodule

// File: rtl/pwr_seq_fsm.sv
// Power sequencing state machine. Low battery has priority in every state.
// The request inputs are used only in OFF. A shared timer measures the
// settling interval and the watchdog hold.
// Assumes: all inputs are synchronous and filtered.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int ENABLE_CYCLES = 8,
    parameter int HOLD_CYCLES   = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_req,
    input  logic lowbatt_act,
    input  logic pll_ok,
    input  logic wdog_expire,
    output logic wdog_run,
    output logic reg_en,
    output logic mcu_rst_n
);

    localparam int TMAX = (ENABLE_CYCLES > HOLD_CYCLES) ? ENABLE_CYCLES : HOLD_CYCLES;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] EN_LAST   = TW'(ENABLE_CYCLES - 1);
    localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD_CYCLES - 1);

    pwr_state_e    state_q, state_d;
    logic [TW-1:0] timer_q;

    // Purpose: choose the next state, with low battery overriding all else.
    always_comb begin
        state_d = state_q;
        if (lowbatt_act) begin
            state_d = PS_FAULT;
        end else begin
            unique case (state_q)
                PS_OFF:       if (pwr_req) state_d = PS_ENABLING;
                PS_ENABLING:  if (timer_q == EN_LAST) state_d = PS_WAIT_PLL;
                PS_WAIT_PLL:  if (pll_ok) state_d = PS_RUN;
                PS_RUN:       if (wdog_expire) state_d = PS_WDOG_HOLD;
                PS_WDOG_HOLD: if (timer_q == HOLD_LAST) state_d = PS_WAIT_PLL;
                PS_FAULT:     state_d = PS_OFF;
                default:      state_d = PS_FAULT;
            endcase
        end
    end

    // Purpose: register the state and restart the timer on each transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_OFF;
            timer_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                timer_q <= '0;
            else if (state_q == PS_ENABLING || state_q == PS_WDOG_HOLD)
                timer_q <= timer_q + 1'b1;
        end
    end

    // Purpose: decode the outputs from the registered state.
    always_comb begin
        reg_en    = (state_q != PS_OFF) && (state_q != PS_FAULT);
        mcu_rst_n = (state_q == PS_RUN);
        wdog_run  = (state_q == PS_RUN);
    end

endmodule

// File: rtl/pwr_seq_top.sv
// Power-up and reset sequencer top. It synchronises the four
// asynchronous inputs and debounces the two power-on request sources.
// It then drives the sequencing FSM and the watchdog.
// Assumes: every input except wdog_kick may be asynchronous to clk.
module pwr_seq_top #(
    parameter int ENABLE_CYCLES = 8,
    parameter int HOLD_CYCLES   = 64,
    parameter int DB_SAMPLES    = 4,
    parameter int WDOG_WIDTH    = 16,
    parameter int WDOG_LOAD     = 65535
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_key_n,
    input  logic chg_det,
    input  logic lowbatt_n,
    input  logic pll_ready_n,
    input  logic wdog_kick,
    output logic reg_en,
    output logic mcu_rst_n
);

    localparam int NSYNC = 4;
    localparam int NREQ  = 2;

    logic [NSYNC-1:0] raw_act;
    logic [NSYNC-1:0] sync_act;
    logic [NREQ-1:0]  req_db;
    logic             pwr_req;
    logic             lowbatt_act;
    logic             pll_ok;
    logic             wdog_run;
    logic             wdog_expire;

    // Purpose: map every input to "1 = active" before synchronising.
    assign raw_act = {~pll_ready_n, ~lowbatt_n, chg_det, ~pwr_key_n};

    pwr_seq_sync #(.WIDTH(NSYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_act),
        .d_out (sync_act)
    );

    // One debounce per power-on source (bit 0 = key, bit 1 = charger).
    for (genvar g = 0; g < NREQ; g++) begin : g_db
        pwr_seq_debounce #(.SAMPLES(DB_SAMPLES)) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .d_in  (sync_act[g]),
            .d_out (req_db[g])
        );
    end

    assign pwr_req     = |req_db;
    assign lowbatt_act = sync_act[2];
    assign pll_ok      = sync_act[3];

    pwr_seq_fsm #(
        .ENABLE_CYCLES (ENABLE_CYCLES),
        .HOLD_CYCLES   (HOLD_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_req     (pwr_req),
        .lowbatt_act (lowbatt_act),
        .pll_ok      (pll_ok),
        .wdog_expire (wdog_expire),
        .wdog_run    (wdog_run),
        .reg_en      (reg_en),
        .mcu_rst_n   (mcu_rst_n)
    );

    pwr_seq_wdog #(
        .WIDTH (WDOG_WIDTH),
        .LOAD  (WDOG_LOAD)
    ) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (wdog_run),
        .kick   (wdog_kick),
        .expire (wdog_expire)
    );

endmodule

// File: rtl/pwr_seq_chk.sv
// Property checker for the power sequencer, bound into every pwr_seq_top.
// Assumes: it sees the top's ports and the synchronised internal levels.
module pwr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic lowbatt_n,
    input logic lowbatt_act,
    input logic pll_ok,
    input logic wdog_kick,
    input logic wdog_expire,
    input logic reg_en,
    input logic mcu_rst_n
);

    // R9: the MCU is never out of reset without its supply.
    p_rst_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mcu_rst_n |-> reg_en);

    // R4: the enable always comes up with the MCU still in reset.
    p_en_rise_in_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_en) |-> !mcu_rst_n);

    // R4: reset release only follows a synchronised PLL-ready level.
    p_release_after_pll_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mcu_rst_n) |-> $past(pll_ok));

    // R5: the enable falls only because of low battery.
    p_en_fall_lowbatt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_en) |-> $past(lowbatt_act));

    // R6: low battery held for three cycles has removed the enable.
    p_lowbatt_drops_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lowbatt_n && $past(!lowbatt_n) && $past(!lowbatt_n, 2)) |=> !reg_en);

    // R8: a kick prevents expiry in the following cycle.
    p_kick_reloads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_kick |=> !wdog_expire);

    // R7: on expiry the enable stays up while the MCU goes into reset.
    p_expiry_keeps_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_expire && !lowbatt_act) |=> (reg_en && !mcu_rst_n));

endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lowbatt_n   (lowbatt_n),
    .lowbatt_act (lowbatt_act),
    .pll_ok      (pll_ok),
    .wdog_kick   (wdog_kick),
    .wdog_expire (wdog_expire),
    .reg_en      (reg_en),
    .mcu_rst_n   (mcu_rst_n)
);

// File: tb/pwr_seq_top_bench.sv
`timescale 1ns/1ps
module pwr_seq_top_bench;

    localparam int ENABLE_CYCLES = 8;
    localparam int HOLD_CYCLES   = 64;
    localparam int WDOG_LOAD     = 300;
    localparam int NVEC          = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_key_n = 1'b1;
    logic chg_det = 1'b0;
    logic lowbatt_n = 1'b1;
    logic pll_ready_n = 1'b1;
    logic wdog_kick = 1'b0;
    logic reg_en;
    logic mcu_rst_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwr_seq_top #(
        .ENABLE_CYCLES (ENABLE_CYCLES),
        .HOLD_CYCLES   (HOLD_CYCLES),
        .DB_SAMPLES    (4),
        .WDOG_WIDTH    (16),
        .WDOG_LOAD     (WDOG_LOAD)
    ) u_pwr_seq_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_key_n   (pwr_key_n),
        .chg_det     (chg_det),
        .lowbatt_n   (lowbatt_n),
        .pll_ready_n (pll_ready_n),
        .wdog_kick   (wdog_kick),
        .reg_en      (reg_en),
        .mcu_rst_n   (mcu_rst_n)
    );

    typedef struct packed {
        logic       key_n;
        logic       chg;
        logic       lb_n;
        logic       pll_n;
        logic       kick;
        logic [7:0] wait_c;
        logic       exp_en;
        logic       exp_rstn;
    } vec_t;

    // key_n, chg, lb_n, pll_n, kick, wait, exp reg_en, exp mcu_rst_n
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd20, 1'b0, 1'b0},  // R1 idle stays off
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd30, 1'b1, 1'b0},  // R2/R4 key, no PLL
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd10, 1'b1, 1'b0},  // R5 key release
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd10, 1'b1, 1'b1},  // R4 PLL ready
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd20, 1'b1, 1'b1},  // R5 key while run
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd20, 1'b1, 1'b1},  // R5 charger while run
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'd10, 1'b0, 1'b0},  // R6 low battery
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd20, 1'b0, 1'b0},  // R6 stays off after
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd40, 1'b1, 1'b1},  // R3 charger start
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd10, 1'b1, 1'b1}   // R5 charger removed
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic kick_once();
        wdog_kick = 1'b1;
        tick(1);
        wdog_kick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog on the bench itself: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lowcnt;
        bit en_drop;
        bit found;
        // R1: reset state
        tick(3);
        check("R1 reg_en in reset", 32'(reg_en), 0);
        check("R1 mcu_rst_n in reset", 32'(mcu_rst_n), 0);
        rst_n = 1'b1;
        tick(1);
        check("R1 reg_en after reset", 32'(reg_en), 0);
        check("R1 mcu_rst_n after reset", 32'(mcu_rst_n), 0);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            pwr_key_n   = VECS[i].key_n;
            chg_det     = VECS[i].chg;
            lowbatt_n   = VECS[i].lb_n;
            pll_ready_n = VECS[i].pll_n;
            wdog_kick   = VECS[i].kick;
            tick(1);
            wdog_kick = 1'b0;
            tick(int'(VECS[i].wait_c) - 1);
            check($sformatf("R2-R6 vec %0d reg_en", i), 32'(reg_en), 32'(VECS[i].exp_en));
            check($sformatf("R4 R5 R6 vec %0d mcu_rst_n", i), 32'(mcu_rst_n), 32'(VECS[i].exp_rstn));
        end

        // R8: regular kicks keep the phone out of reset
        lowcnt = 0;
        for (int i = 0; i < 1000; i++) begin
            if (i % 100 == 0) wdog_kick = 1'b1;
            tick(1);
            wdog_kick = 1'b0;
            if (!mcu_rst_n) lowcnt++;
        end
        check("R8 cycles in reset while kicked", 32'(lowcnt), 0);

        // R7: watchdog expiry, measured hold, enable kept
        kick_once();
        tick(WDOG_LOAD - 10);
        check("R7 still running before expiry", 32'(mcu_rst_n), 1);
        found = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (!found) begin
                tick(1);
                if (!mcu_rst_n) found = 1'b1;
            end
        end
        check("R7 expiry asserted reset", 32'(found), 1);
        lowcnt = 1;
        en_drop = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (!mcu_rst_n) begin
                if (!reg_en) en_drop = 1'b1;
                tick(1);
                if (!mcu_rst_n) lowcnt++;
            end
        end
        check("R7 reg_en held during hold", 32'(en_drop), 0);
        check("R7 hold length in range", 32'(lowcnt >= HOLD_CYCLES && lowcnt <= HOLD_CYCLES + 2), 1);
        check("R7 back in run after hold", 32'(mcu_rst_n), 1);

        // R6: return to OFF through low battery
        lowbatt_n = 1'b0;
        tick(4);
        check("R6 reg_en dropped from run", 32'(reg_en), 0);
        lowbatt_n = 1'b1;
        tick(10);

        // R2: short key glitch filtered
        pwr_key_n = 1'b0;
        tick(2);
        pwr_key_n = 1'b1;
        tick(30);
        check("R2 glitch ignored", 32'(reg_en), 0);

        // R6: low battery during the settling interval
        pwr_key_n = 1'b0;
        tick(6);
        pwr_key_n = 1'b1;
        tick(4);
        check("R2 six-cycle press starts power-up", 32'(reg_en), 1);
        lowbatt_n = 1'b0;
        tick(4);
        check("R6 reg_en dropped during enabling", 32'(reg_en), 0);
        check("R6 mcu_rst_n low during enabling", 32'(mcu_rst_n), 0);
        lowbatt_n = 1'b1;
        tick(20);
        check("R6 no restart without request", 32'(reg_en), 0);

        // R4: PLL not ready keeps reset asserted
        pll_ready_n = 1'b1;
        chg_det = 1'b1;
        tick(60);
        check("R3 charger powers up", 32'(reg_en), 1);
        check("R4 reset held without PLL", 32'(mcu_rst_n), 0);
        chg_det = 1'b0;
        pll_ready_n = 1'b0;
        tick(6);
        check("R4 reset released with PLL", 32'(mcu_rst_n), 1);
        kick_once();

        // R1: reset while running
        rst_n = 1'b0;
        tick(2);
        check("R1 reg_en mid-run reset", 32'(reg_en), 0);
        check("R1 mcu_rst_n mid-run reset", 32'(mcu_rst_n), 0);
        rst_n = 1'b1;
        tick(2);

        finish_run();
    end

endmodule